// File: doc/BRIEF.md
# DS3 Idle Signal Frame Integrator

This block watches a received DS3 stream one M-frame at a time and decides whether each frame carries the idle signal. A frame passes only when its framing bits were received valid, the three C-bits of subframe 3 are all zero, both X-bits are one, and every qualified payload bit follows a repeating 1100 sequence. The payload checker locks its phase on the first two qualified payload bits of the frame and predicts every later bit from there. Any mismatch spoils the frame until its end strobe.

The per-frame verdict drives a 6-bit up/down integrator. The integrator climbs on idle frames, falls on other frames, stops at 0 at the bottom and at 63 at the top. The idle status is set when the integrator reaches 63 and cleared only when it falls back to 0. Every change of the status produces a one-cycle interrupt request. A separate flag reports a far-end receive failure for each frame whose two X-bits are both zero.

Top module: `ds3_idle_integ`

## Requirements
- R1: During and immediately after reset, `idle_stat`, `idle_irq` and `ferf` are 0 and the integrator holds 0.
- R2: A frame whose `m_ok`, `f_ok` or `p_ok` is 0 at its end strobe is not idle.
- R3: A frame is idle only if `cbits` equals 3'b000 at its end strobe. Any set bit makes the frame not idle.
- R4: A frame is idle only if `xbits` equals 2'b11 at its end strobe. The values 2'b01, 2'b10 and 2'b00 make it not idle.
- R5: The payload of an idle frame follows the cyclic sequence 1,1,0,0 starting at any of its four phases. The first two qualified bits fix the phase, and any later mismatch makes the frame not idle. A frame with fewer than two qualified payload bits is not idle.
- R6: At each end strobe, the integrator adds 1 for an idle frame and subtracts 1 for a non-idle frame. A non-idle frame at 0 leaves it at 0.
- R7: An idle frame at 63 leaves the integrator at 63.
- R8: `idle_stat` goes to 1 in the cycle after the end strobe that brings the integrator to 63. It goes to 0 in the cycle after the end strobe that brings it to 0. At every other time it holds.
- R9: `idle_irq` is high for exactly one cycle, the cycle after an end strobe that changed `idle_stat`, and is never high otherwise.
- R10: In the cycle after each end strobe, `ferf` shows 1 if that frame's `xbits` was 2'b00 and 0 otherwise. It holds until the next end strobe.
- R11: Payload bits presented while `pay_vld` is 0 have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_vld | input | 1 | Qualifies `pay_bit` as a payload bit |
| pay_bit | input | 1 | Serial payload bit |
| mf_end | input | 1 | End of M-frame strobe, one cycle |
| m_ok | input | 1 | M-bits of the ending frame were valid |
| f_ok | input | 1 | F-bits of the ending frame were valid |
| p_ok | input | 1 | P-bits of the ending frame were valid |
| cbits | input | 3 | C-bits of subframe 3 of the ending frame |
| xbits | input | 2 | X-bits of the ending frame |
| idle_stat | output | 1 | Idle condition status |
| idle_irq | output | 1 | One-cycle change-of-idle-status request |
| ferf | output | 1 | Far-end receive failure flag |

## Verification
On every cycle, the checker confirms that the integrator moves by at most one step and only at an end strobe. It also confirms that the status and the failure flag hold between strobes, that the status rises only at 63 and falls only at 0, and that an interrupt is a lone pulse that always marks a status change after a strobe. Only the directed scenarios can show that each individual spoiling condition (a framing flag, a C-bit, an X-bit value, a late payload error or a short frame) really costs a step. The same holds for showing that any payload phase is accepted, that unqualified bits are ignored, and that saturation at both ends changes how many frames are needed to declare and clear.

// File: rtl/ds3_idle_pkg.sv
package ds3_idle_pkg;
   localparam int unsigned DS3_CBIT_W = 3;
   localparam int unsigned DS3_XBIT_W = 2;
   localparam logic [DS3_XBIT_W-1:0] XBITS_IDLE = 2'b11;
   localparam logic [DS3_XBIT_W-1:0] XBITS_FERF = 2'b00;
endpackage

// File: rtl/ds3_idle_pat_chk.sv
module ds3_idle_pat_chk #(
   parameter int unsigned          PAT_LEN = 4,
   parameter logic [PAT_LEN-1:0]   PAT     = 4'b1100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pay_vld,
   input  logic pay_bit,
   input  logic mf_end,
   output logic pat_ok
);
   localparam int unsigned PH_W = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;

   function automatic logic pat_at(input int unsigned idx);
      return PAT[PAT_LEN-1-(idx % PAT_LEN)];
   endfunction

   logic [1:0]      seen_q, seen_n;
   logic            b0_q, b0_n;
   logic [PH_W-1:0] ph_q, ph_n;
   logic            bad_q, bad_n;
   logic [PAT_LEN-1:0] cand;
   int unsigned     lock_idx;

   // one candidate start phase per pattern position
   for (genvar s = 0; s < PAT_LEN; s++) begin : g_cand
      assign cand[s] = (PAT[PAT_LEN-1-s] == b0_q) &&
                       (PAT[PAT_LEN-1-((s+1) % PAT_LEN)] == pay_bit);
   end

   always_comb begin
      lock_idx = 0;
      for (int i = PAT_LEN-1; i >= 0; i--) begin
         if (cand[i]) lock_idx = i;
      end
   end

   always_comb begin
      seen_n = seen_q;
      b0_n   = b0_q;
      ph_n   = ph_q;
      bad_n  = bad_q;
      if (pay_vld) begin
         case (seen_q)
            2'd0: begin
               b0_n   = pay_bit;
               seen_n = 2'd1;
            end
            2'd1: begin
               seen_n = 2'd2;
               if (cand == '0) bad_n = 1'b1;
               ph_n = PH_W'((lock_idx + 2) % PAT_LEN);
            end
            default: begin
               if (pay_bit != pat_at(ph_q)) bad_n = 1'b1;
               ph_n = PH_W'((int'(ph_q) + 1) % PAT_LEN);
            end
         endcase
      end
   end

   assign pat_ok = (seen_n == 2'd2) && !bad_n;

   always_ff @(posedge clk) begin
      if (!rst_n || mf_end) begin
         seen_q <= '0;
         b0_q   <= 1'b0;
         ph_q   <= '0;
         bad_q  <= 1'b0;
      end else begin
         seen_q <= seen_n;
         b0_q   <= b0_n;
         ph_q   <= ph_n;
         bad_q  <= bad_n;
      end
   end
endmodule

// File: rtl/ds3_idle_frm_cnt.sv
module ds3_idle_frm_cnt #(
   parameter int unsigned TOP  = 63,
   parameter int unsigned CNT_W = $clog2(TOP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mf_end,
   input  logic             frame_ok,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_n
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TOP);

   always_comb begin
      cnt_n = cnt_q;
      if (mf_end) begin
         if (frame_ok) begin
            if (cnt_q != CNT_TOP) cnt_n = cnt_q + 1'b1;
         end else begin
            if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
   end
endmodule

// File: rtl/ds3_idle_status.sv
module ds3_idle_status
   import ds3_idle_pkg::*;
#(
   parameter int unsigned TOP   = 63,
   parameter int unsigned CNT_W = $clog2(TOP + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mf_end,
   input  logic [CNT_W-1:0]      cnt_n,
   input  logic [DS3_XBIT_W-1:0] xbits,
   output logic                  idle_stat,
   output logic                  idle_irq,
   output logic                  ferf
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TOP);

   logic stat_n;

   always_comb begin
      stat_n = idle_stat;
      if (mf_end) begin
         if (cnt_n == CNT_TOP)  stat_n = 1'b1;
         else if (cnt_n == '0)  stat_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_stat <= 1'b0;
         idle_irq  <= 1'b0;
         ferf      <= 1'b0;
      end else begin
         idle_stat <= stat_n;
         idle_irq  <= stat_n ^ idle_stat;
         if (mf_end) ferf <= (xbits == XBITS_FERF);
      end
   end
endmodule

// File: rtl/ds3_idle_integ.sv
module ds3_idle_integ
   import ds3_idle_pkg::*;
#(
   parameter int unsigned        PAT_LEN = 4,
   parameter logic [PAT_LEN-1:0] PAT     = 4'b1100,
   parameter int unsigned        TOP     = 63
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pay_vld,
   input  logic                  pay_bit,
   input  logic                  mf_end,
   input  logic                  m_ok,
   input  logic                  f_ok,
   input  logic                  p_ok,
   input  logic [DS3_CBIT_W-1:0] cbits,
   input  logic [DS3_XBIT_W-1:0] xbits,
   output logic                  idle_stat,
   output logic                  idle_irq,
   output logic                  ferf
);
   localparam int unsigned CNT_W = $clog2(TOP + 1);

   if (PAT_LEN < 2) begin : g_bad_pat
      $error("PAT_LEN must be at least 2");
   end
   if (TOP < 1) begin : g_bad_top
      $error("TOP must be at least 1");
   end

   logic             pat_ok;
   logic             frame_ok;
   logic [CNT_W-1:0] frm_cnt, frm_cnt_n;

   ds3_idle_pat_chk #(.PAT_LEN(PAT_LEN), .PAT(PAT)) u_pat (
      .clk(clk), .rst_n(rst_n), .pay_vld(pay_vld), .pay_bit(pay_bit),
      .mf_end(mf_end), .pat_ok(pat_ok)
   );

   assign frame_ok = m_ok && f_ok && p_ok && (cbits == '0) &&
                     (xbits == XBITS_IDLE) && pat_ok;

   ds3_idle_frm_cnt #(.TOP(TOP), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mf_end(mf_end), .frame_ok(frame_ok),
      .cnt_q(frm_cnt), .cnt_n(frm_cnt_n)
   );

   ds3_idle_status #(.TOP(TOP), .CNT_W(CNT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .mf_end(mf_end), .cnt_n(frm_cnt_n),
      .xbits(xbits), .idle_stat(idle_stat), .idle_irq(idle_irq), .ferf(ferf)
   );
endmodule

// File: rtl/ds3_idle_integ_chk.sv
module ds3_idle_integ_chk #(
   parameter int unsigned TOP   = 63,
   parameter int unsigned CNT_W = $clog2(TOP + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mf_end,
   input logic             idle_stat,
   input logic             idle_irq,
   input logic             ferf,
   input logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W:0]   ONE     = 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TOP);

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mf_end |=> ({1'b0, cnt} == {1'b0, $past(cnt)} + ONE) ||
                 ({1'b0, $past(cnt)} == {1'b0, cnt} + ONE) ||
                 (cnt == $past(cnt)));

   // R6
   cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_end |=> $stable(cnt));

   // R8
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_end |=> $stable(idle_stat));

   // R8
   stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_stat) |-> cnt == CNT_TOP);

   // R8
   stat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_stat) |-> cnt == '0);

   // R9
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_irq |=> !idle_irq);

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_irq |-> $past(mf_end) && (idle_stat != $past(idle_stat)));

   // R10
   ferf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_end |=> $stable(ferf));
endmodule

bind ds3_idle_integ ds3_idle_integ_chk #(.TOP(TOP), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mf_end(mf_end), .idle_stat(idle_stat),
   .idle_irq(idle_irq), .ferf(ferf), .cnt(frm_cnt)
);

// File: tb/ds3_idle_integ_tb_top.sv
module ds3_idle_integ_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pay_vld = 1'b0, pay_bit = 1'b0, mf_end = 1'b0;
   logic m_ok = 1'b1, f_ok = 1'b1, p_ok = 1'b1;
   logic [2:0] cbits = '0;
   logic [1:0] xbits = 2'b11;
   logic idle_stat, idle_irq, ferf;

   int n_chk = 0, n_bad = 0;
   int mcnt = 0;
   bit mstat = 0;
   bit done = 0;
   localparam logic [3:0] PATB = 4'b1100;

   always #4 clk = ~clk;

   ds3_idle_integ dut_i (
      .clk(clk), .rst_n(rst_n), .pay_vld(pay_vld), .pay_bit(pay_bit),
      .mf_end(mf_end), .m_ok(m_ok), .f_ok(f_ok), .p_ok(p_ok),
      .cbits(cbits), .xbits(xbits), .idle_stat(idle_stat),
      .idle_irq(idle_irq), .ferf(ferf)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one M-frame: payload bits (a wrong bit at err_at, a gap cycle carrying a
   // wrong bit after the third bit), then the end strobe with the given flags
   task automatic send_frame(input logic m, f, p, input logic [2:0] c,
                             input logic [1:0] x, input int nbits,
                             input int phase, input int err_at,
                             input bit exp_idle, input string tag);
      bit old_stat;
      for (int k = 0; k < nbits; k++) begin
         @(negedge clk);
         pay_vld = 1'b1;
         pay_bit = PATB[3 - ((phase + k) % 4)] ^ (k == err_at);
         if (k == 2) begin
            @(negedge clk);
            pay_vld = 1'b0;
            pay_bit = ~PATB[3 - ((phase + k + 1) % 4)];
         end
      end
      @(negedge clk);
      pay_vld = 1'b0;
      mf_end = 1'b1; m_ok = m; f_ok = f; p_ok = p; cbits = c; xbits = x;
      old_stat = mstat;
      if (exp_idle) begin
         if (mcnt < 63) mcnt++;
      end else if (mcnt > 0) mcnt--;
      if (mcnt == 63) mstat = 1;
      else if (mcnt == 0) mstat = 0;
      @(negedge clk);
      mf_end = 1'b0; m_ok = 1'b1; f_ok = 1'b1; p_ok = 1'b1; cbits = '0; xbits = 2'b11;
      check({tag, " R8 status"}, idle_stat, mstat);
      check({tag, " R9 irq"}, idle_irq, int'(mstat != old_stat));
      check({tag, " R10 ferf"}, ferf, int'(x == 2'b00));
      @(negedge clk);
      check({tag, " R9 irq single"}, idle_irq, 0);
      check({tag, " R10 ferf hold"}, ferf, int'(x == 2'b00));
   endtask

   task automatic idle_frame(input string tag);
      send_frame(1, 1, 1, 3'b000, 2'b11, 8, 0, -1, 1, tag);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 stat", idle_stat, 0);
      check("R1 irq", idle_irq, 0);
      check("R1 ferf", ferf, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 stat after", idle_stat, 0);
   endtask

   task automatic t_floor_and_climb();
      // R6 floor: a non-idle frame at zero must not wrap
      send_frame(0, 1, 1, 3'b000, 2'b11, 8, 0, -1, 0, "R6 floor");
      for (int i = 0; i < 62; i++) idle_frame("R11 gap climb");
   endtask

   task automatic t_spoilers();
      send_frame(0, 1, 1, 3'b000, 2'b11, 8, 0, -1, 0, "R2 m bad"); idle_frame("R2 re");
      send_frame(1, 0, 1, 3'b000, 2'b11, 8, 0, -1, 0, "R2 f bad"); idle_frame("R2 re");
      send_frame(1, 1, 0, 3'b000, 2'b11, 8, 0, -1, 0, "R2 p bad"); idle_frame("R2 re");
      send_frame(1, 1, 1, 3'b001, 2'b11, 8, 0, -1, 0, "R3 c0");    idle_frame("R3 re");
      send_frame(1, 1, 1, 3'b010, 2'b11, 8, 0, -1, 0, "R3 c1");    idle_frame("R3 re");
      send_frame(1, 1, 1, 3'b100, 2'b11, 8, 0, -1, 0, "R3 c2");    idle_frame("R3 re");
      send_frame(1, 1, 1, 3'b000, 2'b01, 8, 0, -1, 0, "R4 x01");   idle_frame("R4 re");
      send_frame(1, 1, 1, 3'b000, 2'b10, 8, 0, -1, 0, "R4 x10");   idle_frame("R4 re");
      send_frame(1, 1, 1, 3'b000, 2'b00, 8, 0, -1, 0, "R4 R10 x00"); idle_frame("R10 clear");
      send_frame(1, 1, 1, 3'b000, 2'b11, 8, 1, 6, 0, "R5 late err"); idle_frame("R5 re");
      send_frame(1, 1, 1, 3'b000, 2'b11, 1, 0, -1, 0, "R5 short");  idle_frame("R5 re");
   endtask

   task automatic t_declare();
      // R5 other phase still counts; this frame reaches 63
      send_frame(1, 1, 1, 3'b000, 2'b11, 9, 2, -1, 1, "R5 R8 phase2 declare");
      send_frame(1, 1, 1, 3'b000, 2'b11, 7, 3, -1, 1, "R5 phase3");
   endtask

   task automatic t_saturate_and_clear();
      for (int i = 0; i < 5; i++) idle_frame("R7 saturate");
      // with saturation, 63 non-idle frames clear the status
      for (int i = 0; i < 63; i++)
         send_frame(1, 1, 0, 3'b000, 2'b11, 8, 0, -1, 0, "R7 R8 drain");
      check("R8 cleared", idle_stat, 0);
   endtask

   initial begin
      t_reset();
      t_floor_and_climb();
      t_spoilers();
      t_declare();
      t_saturate_and_clear();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule